// File: doc/BRIEF.md
# MAC Status Word with Clearing Read Views

This block keeps a 64-bit status word for one Ethernet port. The word holds three kinds of bit. Event bits are sticky: a one-cycle pulse sets them and they stay set. Level bits show live conditions as they are. One bit shows that transmission is held off by a pause request. That bit comes from an internal countdown, which is loaded by received pause frames and decremented by a slot-time tick.

Software can read the word through three views selected by a two-bit view code, and each view clears a different set of bits:
- **Clear-all view:** returns the word, then clears every sticky bit.
- **Channel-1 view:** returns the same value, but clears only the sticky bits that belong to the channel-1 transmit and receive DMA. This lets two interrupt handlers share the word without losing each other's events.
- **Peek view:** returns the value and changes nothing, for debug use.

An interrupt output is the OR of the sticky bits that a parameter mask enables.

Top module: `mac_stat_alias_regs`

## Requirements
- R1: After synchronous reset, all 64 bits of the word read as zero and `irq_o` is 0.
- R2: A read with view code 0 returns the whole word as it stood in the strobe cycle, then clears all sticky bits. The sticky bits are bits 39:0.
- R3: A read with view code 1 returns the same value as view 0, but clears only the channel-1 sticky bits (mask 64'h0000_0000_FF00_FF00, which is bits 15:8 and 31:24). All other sticky bits keep their value.
- R4: A read with view code 2 or 3 returns the word and changes no bit.
- R5: An event pulse that arrives in the same cycle as a clearing read is not part of that read's data, but the bit stays set for the next read.
- R6: Bits 51:40 show `lvl_i[51:40]` live and are never held.
- R7: Bit 52 becomes 1 the cycle after a pause frame with a nonzero quanta count is received. It falls on the tick that brings the count to zero, so it stays set for exactly that many `slot_tick_i` pulses.
- R8: A nonzero pause frame that arrives while the count is still running reloads the count with the new value.
- R9: A pause frame with zero quanta clears bit 52 on the next cycle.
- R10: While `fifo_mode_i` is 1, bit 52 reads 0 and pause frames have no effect.
- R11: Bits 63:53 always read 0. An event input on bit 52 or above, or a level input outside bits 51:40, has no effect.
- R12: `irq_o` is the OR of the sticky bits enabled by `IRQ_MASK` (default: all of bits 39:0). Bit 52 never drives it.
- R13: The read data appears on `rd_data_o` in the cycle after `rd_stb_i`, with `rd_vld_o` high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 64 | One-cycle event pulses that set sticky bits |
| lvl_i | input | 64 | Live level conditions |
| rd_stb_i | input | 1 | Read strobe |
| rd_view_i | input | 2 | View code: 0 clear-all, 1 clear channel 1, 2 or 3 peek |
| pause_rx_i | input | 1 | Pause frame received (one-cycle pulse) |
| pause_quanta_i | input | 16 | Pause time carried by the frame |
| slot_tick_i | input | 1 | Slot-time tick that decrements the pause count |
| fifo_mode_i | input | 1 | Port runs in packet FIFO mode |
| rd_data_o | output | 64 | Read data |
| rd_vld_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to produce from the ports is an event landing in the same cycle as a clearing read. The stimulus for it drives an event pulse and a view-0 strobe in the same cycle. It expects that read to lack the event and the next peek to show it.

The pause countdown is also hard to reach. It is tested by counting ticks one at a time and peeking after each one. A second frame sent in the middle of a countdown shows that the count reloads rather than adds.

// File: rtl/macstat_pkg.sv
package macstat_pkg;

    localparam int STAT_W    = 64;
    localparam int PAUSE_POS = 52;
    localparam int TQ_W      = 16;

    localparam logic [STAT_W-1:0] EVT_MASK_DEF = 64'h0000_00FF_FFFF_FFFF;
    localparam logic [STAT_W-1:0] LVL_MASK_DEF = 64'h000F_FF00_0000_0000;
    localparam logic [STAT_W-1:0] CH1_MASK_DEF = 64'h0000_0000_FF00_FF00;

    typedef enum logic [1:0] {
        VIEW_CLR_ALL = 2'b00,
        VIEW_CLR_CH1 = 2'b01,
        VIEW_PEEK    = 2'b10,
        VIEW_PEEK_B  = 2'b11
    } view_e;

    typedef struct packed {
        logic  stb;
        view_e view;
    } rd_req_t;

    function automatic logic [STAT_W-1:0] clear_scope(
        input rd_req_t           req,
        input logic [STAT_W-1:0] all_mask,
        input logic [STAT_W-1:0] ch1_mask
    );
        logic [STAT_W-1:0] m;
        m = '0;
        if (req.stb) begin
            case (req.view)
                VIEW_CLR_ALL: m = all_mask;
                VIEW_CLR_CH1: m = ch1_mask & all_mask;
                default:      m = '0;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/stat_event_latch.sv
module stat_event_latch #(
    parameter int          W    = 64,
    parameter logic [63:0] MASK = 64'hFF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] lat_o
);
    logic [W-1:0] lat_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst)
                    lat_q[i] <= 1'b0;
                else
                    lat_q[i] <= (lat_q[i] & ~clr_i[i]) | set_i[i];
            end
        end else begin : g_tied
            assign lat_q[i] = 1'b0;
        end
    end

    assign lat_o = lat_q;

    // R5: an event pulse wins over a clear in the same cycle
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        |(set_i & MASK[W-1:0]) |=> ((lat_o & $past(set_i & MASK[W-1:0])) == $past(set_i & MASK[W-1:0])));

    // R11: bits outside the sticky mask never hold state
    a_r11_no_stray_latch: assert property (@(posedge clk) disable iff (rst)
        (lat_o & ~MASK[W-1:0]) == '0);

endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer #(
    parameter int TQ_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_i,
    input  logic [TQ_W-1:0] quanta_i,
    input  logic            tick_i,
    input  logic            hold_off_i,
    output logic            active_o
);
    logic [TQ_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold_off_i)
            cnt_q <= '0;
        else if (frame_i)
            cnt_q <= quanta_i;
        else if (tick_i && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0) && !hold_off_i;

    // R8: a frame outside FIFO mode loads its quanta value
    a_r8_reload: assert property (@(posedge clk) disable iff (rst)
        (frame_i && !hold_off_i) |=> (cnt_q == $past(quanta_i)));

    // R9: a zero-quanta frame drops the flag on the next cycle
    a_r9_zero_frame: assert property (@(posedge clk) disable iff (rst)
        (frame_i && (quanta_i == '0)) |=> !active_o);

    // R7: each tick without a frame removes exactly one quantum
    a_r7_count_down: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !frame_i && !hold_off_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R10: FIFO mode keeps the flag low
    a_r10_fifo_low: assert property (@(posedge clk) disable iff (rst)
        hold_off_i |-> !active_o);

endmodule

// File: rtl/stat_read_port.sv
module stat_read_port #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] data_o,
    output logic         vld_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= stb_i;
            if (stb_i)
                data_o <= word_i;
        end
    end

    // R13: data arrives one cycle after the strobe, with valid
    a_r13_vld_follows: assert property (@(posedge clk) disable iff (rst)
        stb_i |=> (vld_o && (data_o == $past(word_i))));

    a_r13_no_spurious_vld: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> !vld_o);

endmodule

// File: rtl/mac_stat_alias_regs.sv
module mac_stat_alias_regs
    import macstat_pkg::*;
#(
    parameter logic [63:0] EVT_MASK = EVT_MASK_DEF,
    parameter logic [63:0] LVL_MASK = LVL_MASK_DEF,
    parameter logic [63:0] CH1_MASK = CH1_MASK_DEF,
    parameter logic [63:0] IRQ_MASK = EVT_MASK_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] evt_i,
    input  logic [63:0] lvl_i,
    input  logic        rd_stb_i,
    input  logic [1:0]  rd_view_i,
    input  logic        pause_rx_i,
    input  logic [15:0] pause_quanta_i,
    input  logic        slot_tick_i,
    input  logic        fifo_mode_i,
    output logic [63:0] rd_data_o,
    output logic        rd_vld_o,
    output logic        irq_o
);
    localparam logic [STAT_W-1:0] PAUSE_BIT = STAT_W'(1) << PAUSE_POS;
    localparam logic [STAT_W-1:0] KEEP_MASK = (EVT_MASK | LVL_MASK) & ~PAUSE_BIT;

    rd_req_t           req;
    logic [STAT_W-1:0] clr_mask;
    logic [STAT_W-1:0] lat;
    logic [STAT_W-1:0] word;
    logic              pause_on;

    assign req      = '{stb: rd_stb_i, view: view_e'(rd_view_i)};
    assign clr_mask = clear_scope(req, EVT_MASK, CH1_MASK);

    stat_event_latch #(.W(STAT_W), .MASK(EVT_MASK)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_i & EVT_MASK),
        .clr_i (clr_mask),
        .lat_o (lat)
    );

    pause_quanta_timer #(.TQ_W(TQ_W)) u_pause (
        .clk        (clk),
        .rst        (rst),
        .frame_i    (pause_rx_i),
        .quanta_i   (pause_quanta_i),
        .tick_i     (slot_tick_i),
        .hold_off_i (fifo_mode_i),
        .active_o   (pause_on)
    );

    always_comb begin
        word = (lat | (lvl_i & LVL_MASK)) & KEEP_MASK;
        word[PAUSE_POS] = pause_on;
    end

    stat_read_port #(.W(STAT_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .stb_i  (rd_stb_i),
        .word_i (word),
        .data_o (rd_data_o),
        .vld_o  (rd_vld_o)
    );

    assign irq_o = |(lat & IRQ_MASK);

    // R4: a peek read leaves every sticky bit that was set still set
    a_r4_peek_keeps: assert property (@(posedge clk) disable iff (rst)
        (rd_stb_i && rd_view_i[1]) |=> ((lat & $past(lat)) == $past(lat)));

    // R3: the channel-1 view keeps all sticky bits outside channel 1
    a_r3_ch1_scope: assert property (@(posedge clk) disable iff (rst)
        (rd_stb_i && (rd_view_i == 2'b01)) |=> ((lat & $past(lat) & ~CH1_MASK) == ($past(lat) & ~CH1_MASK)));

    // R2: clear-all leaves only bits set by same-cycle events
    a_r2_clear_all: assert property (@(posedge clk) disable iff (rst)
        (rd_stb_i && (rd_view_i == 2'b00)) |=> ((lat & ~$past(evt_i & EVT_MASK)) == '0));

    // R11: the top bits of the read data are always zero
    a_r11_top_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[63:53] == '0);

endmodule

// File: tb/tb_mac_stat_alias_regs.sv
`timescale 1ns/1ps
module tb_mac_stat_alias_regs;

    localparam logic [63:0] EVT = 64'h0000_00FF_FFFF_FFFF;
    localparam logic [63:0] LVL = 64'h000F_FF00_0000_0000;
    localparam logic [63:0] CH1 = 64'h0000_0000_FF00_FF00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] evt_i = '0, lvl_i = '0;
    logic        rd_stb_i = 1'b0;
    logic [1:0]  rd_view_i = 2'b00;
    logic        pause_rx_i = 1'b0;
    logic [15:0] pause_quanta_i = '0;
    logic        slot_tick_i = 1'b0;
    logic        fifo_mode_i = 1'b0;
    logic [63:0] rd_data_o;
    logic        rd_vld_o;
    logic        irq_o;

    always #2.5 clk = ~clk;

    mac_stat_alias_regs dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .lvl_i(lvl_i),
        .rd_stb_i(rd_stb_i), .rd_view_i(rd_view_i),
        .pause_rx_i(pause_rx_i), .pause_quanta_i(pause_quanta_i),
        .slot_tick_i(slot_tick_i), .fifo_mode_i(fifo_mode_i),
        .rd_data_o(rd_data_o), .rd_vld_o(rd_vld_o), .irq_o(irq_o)
    );

    int n_chk = 0, n_fail = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] m_lat = '0;
    bit          m_pause = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] m_word();
        logic [63:0] w;
        w = m_lat | (lvl_i & LVL);
        w[52] = m_pause & !fifo_mode_i;
        return w;
    endfunction

    // monitor: pops the scoreboard on every valid read
    always @(negedge clk) begin
        if (!rst && rd_vld_o) begin
            if (exp_q.size() == 0)
                chk(0, "R13 unexpected valid", rd_data_o, '0);
            else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_data_o === e, t, rd_data_o, e);
            end
        end
    end

    task automatic pulse_evt(input logic [63:0] m);
        @(negedge clk); evt_i = m;
        @(negedge clk); evt_i = '0;
        m_lat |= m & EVT;
    endtask

    task automatic rd(input logic [1:0] v, input string tag);
        @(negedge clk);
        rd_stb_i = 1'b1; rd_view_i = v;
        exp_q.push_back(m_word()); tag_q.push_back(tag);
        @(negedge clk);
        rd_stb_i = 1'b0;
        if (v == 2'b00) m_lat = '0;
        else if (v == 2'b01) m_lat &= ~CH1;
    endtask

    task automatic pframe(input logic [15:0] q);
        @(negedge clk); pause_rx_i = 1'b1; pause_quanta_i = q;
        @(negedge clk); pause_rx_i = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); slot_tick_i = 1'b1;
        @(negedge clk); slot_tick_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(irq_o === 1'b0, "R1 irq after reset", {63'b0, irq_o}, 64'h0);
        rd(2'b10, "R1 word zero after reset");

        // R2 clear-all
        pulse_evt(64'h0000_0012_0000_0301);
        chk(irq_o === 1'b1, "R12 irq with sticky bit", {63'b0, irq_o}, 64'h1);
        rd(2'b00, "R2 clear-all returns word");
        rd(2'b10, "R2 after clear-all sticky bits zero");
        chk(irq_o === 1'b0, "R12 irq low after clear", {63'b0, irq_o}, 64'h0);

        // R3 channel-1 view
        pulse_evt(64'h0000_0080_0100_0201);
        rd(2'b01, "R3 ch1 view returns word");
        rd(2'b10, "R3 non-ch1 bits survive");
        rd(2'b00, "R2 clear rest");

        // R4 peek twice, also code 3
        pulse_evt(64'h0000_0000_00F0_0004);
        rd(2'b10, "R4 first peek");
        rd(2'b11, "R4 peek with code 3");
        rd(2'b10, "R4 value unchanged");
        rd(2'b00, "R2 clear");

        // R5 event in the same cycle as a clearing read
        @(negedge clk);
        rd_stb_i = 1'b1; rd_view_i = 2'b00; evt_i = 64'h0000_0000_0000_0040;
        exp_q.push_back(m_word()); tag_q.push_back("R5 same-cycle event not in read");
        @(negedge clk);
        rd_stb_i = 1'b0; evt_i = '0;
        m_lat = 64'h40;
        rd(2'b10, "R5 same-cycle event kept");
        rd(2'b00, "R2 clear");

        // R6 level bits are live
        lvl_i = 64'h0005_0300_0000_0000;
        rd(2'b10, "R6 level bits visible");
        lvl_i = '0;
        rd(2'b10, "R6 level bits follow input low");

        // R11 reserved and out-of-mask inputs ignored
        lvl_i = '1;
        pulse_evt(64'hFFFF_FF00_0000_0000);
        rd(2'b10, "R11 upper bits zero with all inputs high");
        lvl_i = '0;
        chk(irq_o === 1'b0, "R11 out-of-mask events set nothing", {63'b0, irq_o}, 64'h0);

        // R7 pause countdown of 3 ticks
        pframe(16'd3); m_pause = 1;
        rd(2'b10, "R7 pause set");
        chk(irq_o === 1'b0, "R12 pause bit does not raise irq", {63'b0, irq_o}, 64'h0);
        tick(); tick();
        rd(2'b10, "R7 pause after two ticks");
        tick(); m_pause = 0;
        rd(2'b10, "R7 pause falls at zero");

        // R8 reload mid countdown
        pframe(16'd2); m_pause = 1;
        tick();
        pframe(16'd5);
        for (int i = 0; i < 4; i++) tick();
        rd(2'b10, "R8 still paused after reload");
        tick(); m_pause = 0;
        rd(2'b10, "R8 falls after new count");

        // R9 zero-quanta frame
        pframe(16'd100); m_pause = 1;
        rd(2'b10, "R9 paused before zero frame");
        pframe(16'd0); m_pause = 0;
        rd(2'b10, "R9 zero frame clears");

        // R10 FIFO mode
        pframe(16'd50); m_pause = 1;
        @(negedge clk); fifo_mode_i = 1'b1;
        rd(2'b10, "R10 forced low in FIFO mode");
        m_pause = 0;
        pframe(16'd7);
        @(negedge clk); fifo_mode_i = 1'b0;
        rd(2'b10, "R10 frames ignored in FIFO mode");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R13 all reads returned", 64'(exp_q.size()), 64'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule